// File: doc/BRIEF.md
# Flash Controller Chip-Select Sequencer

This block owns the active-low chip-select lines of a serial flash controller that serves several devices. Every chip select has its own control word. Software writes that word to move a device in and out of the raw-transfer mode, in which it drives serial transfers by hand. The block works out from each write whether the line for that device should be held low. It then drives the line and tracks the progress of a per-device command snoop counter.

Each chip select keeps one flag that marks it as released. A write changes the line only when the newly computed state differs from that flag, so repeated writes in raw-transfer mode never pulse the line. The snoop counter restarts each time a device becomes selected. It is switched off when the device is released, and it advances on an external step strobe while it is on. At most one line is low at any time.

Top module: `spi_cs_ctrl`

## Requirements
- R1: After reset every chip-select line is high, every snoop counter is off at index 0, and every control word reads back as 0.
- R2: A write whose mode field (bits [1:0]) equals the raw-transfer code 2'b11, made while the previous mode was something else, drives that chip select low one cycle later. The stop bit (bit 2) has no effect on this.
- R3: A write whose mode field is anything other than 2'b11 leaves that chip select high after the write.
- R4: While the previous and new modes are both 2'b11, a change of bit 2 from 0 to 1 releases the line, and the mode reads back as 2'b11. Any other raw-transfer write while released (bit 2 staying 1, or 1 to 0) selects again.
- R5: Raw-transfer writes that keep the line selected leave it low in every cycle and do not restart the snoop index.
- R6: When a line becomes selected, its snoop counter turns on at index 0. Each step strobe then adds one, saturating at 2^SNOOP_W-1. A restart in the same cycle wins over a step. Release turns the counter off at index 0.
- R7: Every write stores its full control word, and the word reads back through the read port whether or not the line changed. A read index that is not mapped returns 0.
- R8: A write to one chip select changes neither the line nor the control word of any other.
- R9: A request to select a line while another line is low leaves the requested line high. Once the other line is released, a later raw-transfer write selects it.
- R10: A write whose index is NUM_CS or above changes no line and no control word.
- R11: Step strobes have no effect on a snoop counter that is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_sel_i | input | SEL_W | Chip-select index of the write |
| wr_data_i | input | CTRL_W | Control word written |
| rd_sel_i | input | SEL_W | Chip-select index read back |
| rd_data_o | output | CTRL_W | Stored control word of rd_sel_i |
| step_i | input | NUM_CS | Snoop step strobe per chip select |
| cs_no | output | NUM_CS | Chip-select lines, active low |
| snoop_on_o | output | NUM_CS | Snoop counter running, per chip select |
| snoop_idx_o | output | NUM_CS*SNOOP_W | Snoop index, SNOOP_W bits per chip select |

## Verification
The bench builds the block with NUM_CS=3 and SNOOP_W=2. Three lines are enough to show the one-line-low rule and the isolation of neighbours. They also leave index 3 of the 2-bit select unmapped, which exercises the ignored-write and zero-readback cases. A 2-bit snoop index reaches saturation after three steps, so the saturation limit and its survival through repeated raw-transfer writes are tested directly.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  parameter int unsigned MODE_W = 2;
  parameter logic [MODE_W-1:0] MODE_USER = 2'b11;
  parameter int unsigned STOP_POS = 2;
endpackage

// File: rtl/spi_cs_decode.sv
module spi_cs_decode
  import spi_cs_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] old_ctrl_i,
  input  logic [CTRL_W-1:0] new_ctrl_i,
  input  logic              cur_unsel_i,
  input  logic              busy_i,
  output logic              nxt_unsel_o,
  output logic              change_o
);
  logic old_user, new_user, stop_rise, req_unsel;

  assign old_user  = old_ctrl_i[MODE_W-1:0] == MODE_USER;
  assign new_user  = new_ctrl_i[MODE_W-1:0] == MODE_USER;
  assign stop_rise = !old_ctrl_i[STOP_POS] && new_ctrl_i[STOP_POS];
  // release on leaving raw mode, or on stop rising while staying in it
  assign req_unsel = !new_user || (old_user && stop_rise);
  // a competing active line blocks selection
  assign nxt_unsel_o = req_unsel || busy_i;
  assign change_o    = nxt_unsel_o != cur_unsel_i;
endmodule

// File: rtl/spi_cs_snoop.sv
module spi_cs_snoop #(
  parameter int unsigned SNOOP_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               step_i,
  output logic               on_o,
  output logic [SNOOP_W-1:0] idx_o
);
  localparam logic [SNOOP_W-1:0] IDX_MAX = {SNOOP_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_o  <= 1'b0;
      idx_o <= '0;
    end else if (start_i) begin
      on_o  <= 1'b1;
      idx_o <= '0;
    end else if (stop_i) begin
      on_o  <= 1'b0;
      idx_o <= '0;
    end else if (step_i && on_o && idx_o != IDX_MAX) begin
      idx_o <= idx_o + 1'b1;
    end
  end

  p_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> on_o && idx_o == '0);
  p_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !on_o && idx_o == '0);
  p_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_o && idx_o == IDX_MAX && !start_i && !stop_i |=> idx_o == IDX_MAX);
  p_step_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_o && !start_i |=> !on_o && idx_o == '0);
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int unsigned NUM_CS  = 3,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned SNOOP_W = 4,
  localparam int unsigned SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [SEL_W-1:0]            wr_sel_i,
  input  logic [CTRL_W-1:0]           wr_data_i,
  input  logic [SEL_W-1:0]            rd_sel_i,
  output logic [CTRL_W-1:0]           rd_data_o,
  input  logic [NUM_CS-1:0]           step_i,
  output logic [NUM_CS-1:0]           cs_no,
  output logic [NUM_CS-1:0]           snoop_on_o,
  output logic [NUM_CS*SNOOP_W-1:0]   snoop_idx_o
);
  logic [CTRL_W-1:0] ctrl_q [NUM_CS];
  logic [NUM_CS-1:0] unsel_q;
  logic [NUM_CS-1:0] wr_hit, busy, nxt_unsel, change, apply;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign wr_hit[k] = wr_en_i && (wr_sel_i == SEL_W'(k));
    // another line already low
    assign busy[k]   = |(~unsel_q & ~(NUM_CS'(1) << k));
    assign apply[k]  = wr_hit[k] && change[k];

    spi_cs_decode #(.CTRL_W(CTRL_W)) u_dec (
      .old_ctrl_i (ctrl_q[k]),
      .new_ctrl_i (wr_data_i),
      .cur_unsel_i(unsel_q[k]),
      .busy_i     (busy[k]),
      .nxt_unsel_o(nxt_unsel[k]),
      .change_o   (change[k])
    );

    spi_cs_snoop #(.SNOOP_W(SNOOP_W)) u_snoop (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(apply[k] && !nxt_unsel[k]),
      .stop_i (apply[k] && nxt_unsel[k]),
      .step_i (step_i[k]),
      .on_o   (snoop_on_o[k]),
      .idx_o  (snoop_idx_o[k*SNOOP_W +: SNOOP_W])
    );

    p_user_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit[k] && wr_data_i[MODE_W-1:0] == MODE_USER
      && ctrl_q[k][MODE_W-1:0] != MODE_USER && !busy[k] |=> !cs_no[k]);
    p_exit_rel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit[k] && wr_data_i[MODE_W-1:0] != MODE_USER |=> cs_no[k]);
    p_stop_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit[k] && ctrl_q[k][MODE_W-1:0] == MODE_USER && !ctrl_q[k][STOP_POS]
      && wr_data_i[MODE_W-1:0] == MODE_USER && wr_data_i[STOP_POS] |=> cs_no[k]);
    p_no_repulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit[k] && !cs_no[k] && wr_data_i[MODE_W-1:0] == MODE_USER
      && !(!ctrl_q[k][STOP_POS] && wr_data_i[STOP_POS]) |=> !cs_no[k]);
    p_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit[k] |=> ctrl_q[k] == $past(wr_data_i));
    p_isolate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_hit[k] |=> $stable(cs_no[k]) && $stable(ctrl_q[k]));
    p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_hit[k] && busy[k] && cs_no[k] |=> cs_no[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unsel_q <= '1;
      for (int k = 0; k < NUM_CS; k++) ctrl_q[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_CS; k++) begin
        if (wr_hit[k]) ctrl_q[k] <= wr_data_i;
        if (apply[k])  unsel_q[k] <= nxt_unsel[k];
      end
    end
  end

  assign cs_no = unsel_q;

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_CS; k++)
      if (rd_sel_i == SEL_W'(k)) rd_data_o = ctrl_q[k];
  end

  p_one_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);
  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && int'(wr_sel_i) >= NUM_CS |=> $stable(cs_no));
endmodule

// File: tb/spi_cs_ctrl_bench.sv
`timescale 1ns/1ps
module spi_cs_ctrl_bench;
  localparam int NCS = 3;
  localparam int CW  = 8;
  localparam int SW  = 2;
  localparam logic [SW-1:0] SMAX = {SW{1'b1}};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [CW-1:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [CW-1:0] rd_data;
  logic [NCS-1:0] step = '0;
  logic [NCS-1:0] cs_n, son;
  logic [NCS*SW-1:0] sidx;

  always #2.5 clk = ~clk;

  spi_cs_ctrl #(.NUM_CS(NCS), .CTRL_W(CW), .SNOOP_W(SW)) u_spi_cs_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .step_i(step), .cs_no(cs_n), .snoop_on_o(son), .snoop_idx_o(sidx));

  typedef struct {
    int due;
    logic [NCS-1:0] cs;
    logic [NCS-1:0] on;
    logic [NCS*SW-1:0] idx;
    logic [CW-1:0] rd;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [CW-1:0] ctrl_m [NCS];
  logic [NCS-1:0] unsel_m = '1;
  logic [NCS-1:0] on_m = '0;
  logic [SW-1:0] idx_m [NCS];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic model(bit we, int sel, logic [CW-1:0] d, logic [NCS-1:0] st);
    logic want, busy;
    for (int k = 0; k < NCS; k++)
      if (st[k] && on_m[k] && idx_m[k] != SMAX) idx_m[k] = idx_m[k] + 1'b1;
    if (we && sel < NCS) begin
      want = (d[1:0] != 2'b11) ||
             (ctrl_m[sel][1:0] == 2'b11 && !ctrl_m[sel][2] && d[2]);
      busy = 1'b0;
      for (int j = 0; j < NCS; j++) if (j != sel && !unsel_m[j]) busy = 1'b1;
      if (!want && busy) want = 1'b1;
      if (want != unsel_m[sel]) begin
        unsel_m[sel] = want;
        on_m[sel] = !want;
        idx_m[sel] = '0;
      end
      ctrl_m[sel] = d;
    end
  endtask

  task automatic op(bit we, int sel, logic [CW-1:0] d, logic [NCS-1:0] st,
                    int rs, string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_sel = 2'(sel); wr_data = d; step = st; rd_sel = 2'(rs);
    model(we, sel, d, st);
    e.due = cyc + 1;
    e.cs = unsel_m;
    e.on = on_m;
    for (int k = 0; k < NCS; k++) e.idx[k*SW +: SW] = idx_m[k];
    e.rd = (rs < NCS) ? ctrl_m[rs] : '0;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int rs, string tag);
    op(1'b0, 0, '0, '0, rs, tag);
  endtask

  // monitor: compare expected snapshot after its edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        e = q.pop_front();
        checks++;
        if (cs_n !== e.cs || son !== e.on || sidx !== e.idx || rd_data !== e.rd) begin
          errors++;
          $display("FAIL %s: cs=%b on=%b idx=%h rd=%h expected cs=%b on=%b idx=%h rd=%h",
                   e.tag, cs_n, son, sidx, rd_data, e.cs, e.on, e.idx, e.rd);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NCS; k++) begin ctrl_m[k] = '0; idx_m[k] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state on each index
    idle(0, "R1 reset cs0");
    idle(1, "R1 reset cs1");
    idle(2, "R1 reset cs2");
    // R2 enter raw mode; R6 snoop restart
    op(1, 0, 8'h03, '0, 0, "R2 select cs0");
    op(0, 0, '0, 3'b001, 0, "R6 step 1");
    op(0, 0, '0, 3'b001, 0, "R6 step 2");
    op(0, 0, '0, 3'b001, 0, "R6 step 3");
    op(0, 0, '0, 3'b001, 0, "R6 saturate");
    // R5 repeated raw writes hold line and index
    op(1, 0, 8'h03, '0, 0, "R5 repeat write");
    op(1, 0, 8'h13, '0, 0, "R5 repeat write other bits");
    idle(0, "R5 idle after repeat");
    // R4 stop rising releases, mode stays raw
    op(1, 0, 8'h07, '0, 0, "R4 stop rise release");
    op(0, 0, '0, 3'b001, 0, "R11 step while off");
    op(1, 0, 8'h07, '0, 0, "R4 stop held reselect");
    op(1, 0, 8'h03, 3'b001, 0, "R4 stop fall stays");
    op(1, 0, 8'h07, '0, 0, "R4 second release");
    // R2 stop bit ignored on entry
    op(1, 0, 8'h01, '0, 0, "R3 leave raw cs0");
    op(1, 0, 8'h07, '0, 0, "R2 entry with stop set");
    op(1, 0, 8'h02, '0, 0, "R3 mode 10 release");
    op(1, 0, 8'h03, 3'b001, 0, "R6 start beats step");
    // R9 competing selection
    op(1, 1, 8'h03, '0, 1, "R9 cs1 blocked");
    op(1, 1, 8'hA1, '0, 1, "R7 store while blocked");
    idle(0, "R8 cs0 untouched");
    op(1, 1, 8'h03, '0, 1, "R9 cs1 still blocked");
    op(1, 0, 8'h00, '0, 0, "R3 release cs0");
    op(1, 1, 8'h03, '0, 1, "R9 cs1 selects after release");
    // R10 unmapped index
    op(1, 3, 8'h00, '0, 3, "R10 unmapped write");
    idle(1, "R10 cs1 held");
    // R8 neighbour writes
    op(1, 2, 8'h5C, '0, 2, "R8 cs2 write");
    idle(1, "R8 cs1 unaffected");
    op(1, 1, 8'h02, 3'b010, 1, "R3 cs1 release");
    op(1, 2, 8'h03, 3'b100, 2, "R2 cs2 select");
    op(0, 0, '0, 3'b111, 2, "R11 only running counter steps");
    idle(0, "R1 cs0 readback");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule